// File: doc/BRIEF.md
# Direction-Controlled Bidirectional Port with Peripheral Takeover

This block is a general-purpose bidirectional port. Each bit has a direction flag and a stored output value, and the port as a whole has a mode flag that selects either push-pull or open-drain (wired-OR) driving. Software sets all three through a small synchronous register bus. Each pin is presented to the pad ring as an output-enable and an output-value pair, and the level seen at the pad comes back on its own input.

On-chip peripherals can claim individual bits in two ways. A forcing claim makes the bit an output that carries peripheral data, whatever its direction flag holds. A gated claim substitutes peripheral data but still obeys the direction flag, so a peripheral can turn its driver off for half-duplex links. Neither kind of claim alters the stored output value. When the claim is released, the bit goes back to exactly what the direction flag and stored value specify.

A read of the data address returns the pad level for bits that are not driven. For bits that are driven, it returns the value on the inside of the output driver. This keeps the written value visible when an open-drain pin is pulled low elsewhere.

Top module: `dirport`

## Requirements
- R1: After reset, every direction flag, every stored output value and the open-drain mode flag are 0, so with no peripheral claims no pin is driven.
- R2: With no claim on a bit and its direction flag at 1 (push-pull mode), `pad_oe` is 1 and `pad_out` equals the stored output value of that bit.
- R3: With no claim on a bit and its direction flag at 0, `pad_oe` is 0 for that bit.
- R4: While `per_force` is 1 for a bit (push-pull mode), `pad_oe` is 1 and `pad_out` equals `per_data` for that bit, whatever its direction flag.
- R5: Peripheral claims never change the stored output value. Once every claim on a bit is released, the bit behaves as R2 or R3 describe, using the value written before or during the claim.
- R6: While `per_gate` is 1 and `per_force` is 0 for a bit, the bit is enabled only if its direction flag is 1, and the driven value is `per_data`. `per_force` takes priority over `per_gate`.
- R7: The bus address decodes as follows: 0 selects the stored output values, 1 the direction flags, and 2 the mode, where bit 0 is 1 for open-drain. Address 3 reads as zero. A write takes effect at the clock edge where `bus_wr` is 1. `bus_rdata` is a register that, at each clock edge, captures the contents of the location that `bus_addr` selects.
- R8: A read of address 0 returns, for each bit, the internally driven value if the bit is enabled as an output (direction 1 or forced), and otherwise the `pad_in` level.
- R9: In open-drain mode an enabled bit has `pad_oe` at 1 only when its driven value is 0. `pad_out` is 0 for every bit, so the port never drives high. The read of R8 still returns the internal value.
- R10: A write to address 0 is stored whatever the direction flags and claims are, and it appears on the pin once that bit is driven from the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| per_force | input | WIDTH | Per-bit forcing claim by a peripheral |
| per_gate | input | WIDTH | Per-bit claim that honours the direction flag |
| per_data | input | WIDTH | Peripheral output data |
| pad_in | input | WIDTH | Level observed at each pad |
| pad_oe | output | WIDTH | Pad output enable |
| pad_out | output | WIDTH | Pad output value |

## Verification
The bench builds the port with WIDTH set to 4 and open-drain support enabled. At that width it can visit every combination of direction flags and stored values in both driving modes. For each of these 512 configurations, it applies four arithmetically derived mixes of forcing claims, gated claims, peripheral data and pad levels. The last mix releases every claim, which checks the clean return after a takeover. Separate steps cover writes made during a full takeover, readback of each address and the reset state.

// File: rtl/dirport_pkg.sv
package dirport_pkg;
   localparam int ADDR_W = 2;
   typedef enum logic [ADDR_W-1:0] {
      A_LATCH = 2'd0,
      A_DIR   = 2'd1,
      A_MODE  = 2'd2,
      A_NONE  = 2'd3
   } addr_e;
   localparam int MODE_OD_BIT = 0;
endpackage

// File: rtl/dirport_regs.sv
module dirport_regs
   import dirport_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter bit OD_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] dir_q,
   output logic             od_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_LATCH) latch_q <= bus_wdata;
         if (bus_addr == A_DIR)   dir_q   <= bus_wdata;
      end
   end

   generate
      if (OD_SUPPORT) begin : g_od
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               od_q <= 1'b0;
            else if (bus_wr && bus_addr == A_MODE)
               od_q <= bus_wdata[MODE_OD_BIT];
         end
      end else begin : g_no_od
         assign od_q = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dirport_pinmux.sv
module dirport_pinmux #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic             od_q,
   input  logic [WIDTH-1:0] per_force,
   input  logic [WIDTH-1:0] per_gate,
   input  logic [WIDTH-1:0] per_data,
   output logic [WIDTH-1:0] drv_en,
   output logic [WIDTH-1:0] drv_lvl,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic claimed;
      assign claimed    = per_force[i] | per_gate[i];
      assign drv_en[i]  = per_force[i] | dir_q[i];
      assign drv_lvl[i] = claimed ? per_data[i] : latch_q[i];
      assign pad_oe[i]  = drv_en[i] & (od_q ? ~drv_lvl[i] : 1'b1);
      assign pad_out[i] = od_q ? 1'b0 : drv_lvl[i];
   end
endmodule

// File: rtl/dirport_readback.sv
module dirport_readback
   import dirport_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  latch_q,
   input  logic [WIDTH-1:0]  dir_q,
   input  logic              od_q,
   input  logic [WIDTH-1:0]  drv_en,
   input  logic [WIDTH-1:0]  drv_lvl,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  bus_rdata
);
   logic [WIDTH-1:0] data_view;
   logic [WIDTH-1:0] rd_mux;

   for (genvar i = 0; i < WIDTH; i++) begin : g_view
      assign data_view[i] = drv_en[i] ? drv_lvl[i] : pad_in[i];
   end

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         A_LATCH: rd_mux = data_view;
         A_DIR:   rd_mux = dir_q;
         A_MODE:  rd_mux[MODE_OD_BIT] = od_q;
         default: rd_mux = '0;
      endcase
   end

   logic unused_latch;
   assign unused_latch = ^latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/dirport.sv
module dirport
   import dirport_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter bit OD_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  per_force,
   input  logic [WIDTH-1:0]  per_gate,
   input  logic [WIDTH-1:0]  per_data,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_out
);
   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("dirport: WIDTH must lie in 1..32");
   end

   logic [WIDTH-1:0] latch_q, dir_q, drv_en, drv_lvl;
   logic             od_q;

   dirport_regs #(.WIDTH(WIDTH), .OD_SUPPORT(OD_SUPPORT)) i_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q), .od_q(od_q)
   );

   dirport_pinmux #(.WIDTH(WIDTH)) i_pinmux (
      .latch_q(latch_q), .dir_q(dir_q), .od_q(od_q),
      .per_force(per_force), .per_gate(per_gate), .per_data(per_data),
      .drv_en(drv_en), .drv_lvl(drv_lvl), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   dirport_readback #(.WIDTH(WIDTH)) i_readback (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .latch_q(latch_q),
      .dir_q(dir_q), .od_q(od_q), .drv_en(drv_en), .drv_lvl(drv_lvl),
      .pad_in(pad_in), .bus_rdata(bus_rdata)
   );
endmodule

// File: rtl/dirport_chk.sv
module dirport_chk
   import dirport_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  per_force,
   input logic [WIDTH-1:0]  per_gate,
   input logic [WIDTH-1:0]  per_data,
   input logic [WIDTH-1:0]  pad_oe,
   input logic [WIDTH-1:0]  pad_out,
   input logic [WIDTH-1:0]  latch_q,
   input logic [WIDTH-1:0]  dir_q,
   input logic              od_q
);
   logic unused_in;
   assign unused_in = ^per_gate;

   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dir_q == '0 && latch_q == '0 && !od_q));

   a_r3_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      ((~dir_q & ~per_force & pad_oe) == '0));

   a_r4_force_drives: assert property (@(posedge clk) disable iff (!rst_n)
      ((per_force & (od_q ? ~per_data : {WIDTH{1'b1}}) & ~pad_oe) == '0));

   a_r5_latch_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == A_LATCH) |=> $stable(latch_q));

   a_r7_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_DIR) |=> (bus_rdata == $past(dir_q)));

   a_r9_no_high_drive: assert property (@(posedge clk) disable iff (!rst_n)
      od_q |-> ((pad_oe & pad_out) == '0));
endmodule

bind dirport dirport_chk #(.WIDTH(WIDTH)) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .per_force(per_force), .per_gate(per_gate),
   .per_data(per_data), .pad_oe(pad_oe), .pad_out(pad_out),
   .latch_q(latch_q), .dir_q(dir_q), .od_q(od_q)
);

// File: tb/test_dirport.sv
module test_dirport;
   localparam int W = 4;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic [1:0]   bus_addr = 2'd0;
   logic [W-1:0] bus_wdata = '0, bus_rdata;
   logic [W-1:0] per_force = '0, per_gate = '0, per_data = '0, pad_in = '0;
   logic [W-1:0] pad_oe, pad_out;
   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dirport #(.WIDTH(W), .OD_SUPPORT(1'b1)) i_dirport (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_force(per_force),
      .per_gate(per_gate), .per_data(per_data), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] en, lvl, eoe, eout, erd;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 pad_oe", pad_oe, '0);
      rst_n = 1'b1;
      bus_addr = 2'd1; @(negedge clk);
      check("R1 dir", bus_rdata, '0);
      bus_addr = 2'd2; @(negedge clk);
      check("R1 mode", bus_rdata, '0);
      pad_in = 4'h9; bus_addr = 2'd0; @(negedge clk);
      check("R1 data reads pad", bus_rdata, 4'h9);

      // Sweep: R2 R3 R4 R5 R6 R8 R9
      for (int od = 0; od < 2; od++) begin
         for (int dv = 0; dv < 16; dv++) begin
            for (int lv = 0; lv < 16; lv++) begin
               wr(2'd0, W'(lv));
               wr(2'd1, W'(dv));
               wr(2'd2, W'(od));
               for (int p = 0; p < 4; p++) begin
                  if (p == 3) begin
                     per_force = '0; per_gate = '0;
                  end else begin
                     per_force = W'((dv * 3 + lv + p * 5) & 4'hA);
                     per_gate  = W'((lv * 7 + p * 3 + dv) & 4'h7);
                  end
                  per_data = W'(lv * 5 + dv + p * 11);
                  pad_in   = W'(dv * 9 + p * 7 + 3);
                  bus_addr = 2'd0;
                  @(negedge clk);
                  en   = per_force | W'(dv);
                  lvl  = ((per_force | per_gate) & per_data) | (~(per_force | per_gate) & W'(lv));
                  eoe  = (od != 0) ? (en & ~lvl) : en;
                  eout = (od != 0) ? '0 : lvl;
                  erd  = (en & lvl) | (~en & pad_in);
                  check("R2/R3/R4/R5/R6/R9 pad_oe", pad_oe, eoe);
                  check("R2/R4/R5/R6/R9 pad_out", pad_out & eoe | (od != 0 ? pad_out : '0), eout & eoe);
                  check("R8/R9 data read", bus_rdata, erd);
               end
            end
         end
      end

      // R10: write while fully forced, then release
      wr(2'd2, 4'h0);
      wr(2'd1, 4'h0);
      per_force = 4'hF; per_gate = '0; per_data = 4'h0;
      wr(2'd0, 4'hC);
      @(negedge clk);
      check("R10 forced pin ignores latch", pad_out, 4'h0);
      per_force = '0;
      wr(2'd1, 4'hF);
      check("R10 latch shows after release", pad_out, 4'hC);
      check("R10 oe after release", pad_oe, 4'hF);

      // R7: address decode and read latency
      bus_addr = 2'd1; @(negedge clk);
      check("R7 dir readback", bus_rdata, 4'hF);
      wr(2'd2, 4'h1);
      bus_addr = 2'd2; @(negedge clk);
      check("R7 mode readback", bus_rdata, 4'h1);
      bus_addr = 2'd3; @(negedge clk);
      check("R7 unused address", bus_rdata, 4'h0);
      wr(2'd3, 4'hF);
      bus_addr = 2'd0; @(negedge clk);
      check("R7 write to unused address", bus_rdata, 4'hC);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule